// File: doc/BRIEF.md
# Multi-Driver Bus Resolver

This block stands in for a shared tri-state net in a design that must stay two-state. Each internal drive point supplies a value vector and a per-bit enable vector. An external source joins as one more driver through its own value and enable inputs. The block resolves every bit with a wired-OR of the enabled values. It reports which bits are actively driven, which bits have more than one driver, and which bits carry an unknown marker.

A bit that no driver enables takes a default that elaboration fixes. The choices are:
- a parameterizable unknown marker, which is the safest choice;
- zero, which is the cheapest choice;
- a pull-up or a pull-down constant, which also forces the driven flag high.

A second parameter sets the conflict policy. The block can accept the wired-OR result on a contested bit, or it can replace that bit with the unknown marker. The conflict flag is raised in both cases. The logic is purely combinational and is meant to sit at the lowest level of the hierarchy that sees every driver of the net.

Top module: `multi_driver_resolver`

## Requirements
- R1: On a bit where exactly one driver (internal or external) has its enable at 1, the resolved value equals that driver's value bit.
- R2: Without a pull (undriven mode 0 or 1), the driven flag of a bit equals the OR of all driver enables for that bit, the external enable included.
- R3: In undriven mode 0 (unknown), a bit with no enabled driver resolves to the matching bit of the UNKNOWN_VALUE parameter and raises its unknown flag.
- R4: In undriven mode 1 (zero), a bit with no enabled driver resolves to 0 and its unknown flag stays at 0.
- R5: In undriven mode 2 (pull-up), a bit with no enabled driver resolves to 1, and the driven flag is 1 on every bit regardless of enables.
- R6: In undriven mode 3 (pull-down), a bit with no enabled driver resolves to 0, and the driven flag is 1 on every bit regardless of enables.
- R7: The conflict flag of a bit is 1 exactly when two or more drivers enable that bit, even if their values agree, and it is raised under both conflict policies.
- R8: With CONFLICT_POISON=1, a conflicting bit resolves to the matching UNKNOWN_VALUE bit and raises its unknown flag.
- R9: With CONFLICT_POISON=0, a conflicting bit resolves to the OR of the enabled drivers' values, and its unknown flag stays at 0 unless rule R3 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| drv_val | input | NUM_DRV*WIDTH | Values of the internal drivers; driver d occupies bits [d*WIDTH +: WIDTH] |
| drv_en | input | NUM_DRV*WIDTH | Per-bit enables of the internal drivers, same packing as drv_val |
| ext_val | input | WIDTH | Value offered by the external source |
| ext_en | input | WIDTH | Per-bit enable of the external source |
| res_val | output | WIDTH | Resolved net value |
| res_driven | output | WIDTH | Per-bit flag that the net is driven (forced high when a pull is fitted) |
| res_conflict | output | WIDTH | Per-bit flag that two or more drivers enable the bit |
| res_unknown | output | WIDTH | Per-bit flag that the resolved bit is the unknown marker |

## Verification
The bench runs through every combination of the four enables on every lane, together with every value pattern. This finds any design that loses the external driver, or that miscounts the drivers on a bit. The bench also applies two enabled drivers that agree in value. A design that compared values instead of counting enables would then clear the conflict flag.

The same stimulus drives four configurations at once: unknown with poison, zero with accept, pull-up with poison, and pull-down with accept. A design with a swapped pull constant, with a driven flag not forced under a pull, or with poison applied in accept mode therefore shows a mismatch on the affected instance. The pull-up instance uses a non-uniform unknown marker. A design that hard-coded an all-ones poison value would leave the marker's zero bits wrong.

// File: rtl/mdr_pkg.sv
// Package: shared types for the multi-driver bus resolver.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package mdr_pkg;

    // Resolution of a bit that no driver enables.
    typedef enum logic [1:0] {
        UNDRV_UNKNOWN  = 2'd0,
        UNDRV_ZERO     = 2'd1,
        UNDRV_PULLUP   = 2'd2,
        UNDRV_PULLDOWN = 2'd3
    } undrv_mode_e;

    // True when a pull resistor is modelled on the net.
    function automatic bit mode_has_pull(undrv_mode_e m);
        return (m == UNDRV_PULLUP) || (m == UNDRV_PULLDOWN);
    endfunction

endpackage

// File: rtl/mdr_lane_merge.sv
// Module: mdr_lane_merge
// Builds the wired-OR of enable-qualified driver values and the OR of the
// enables for every bit lane.
// Assumes: drivers are packed driver-major, WIDTH bits each.
module mdr_lane_merge #(
    parameter int WIDTH  = 8,
    parameter int N_TOT  = 4
) (
    input  logic [N_TOT*WIDTH-1:0] all_val,
    input  logic [N_TOT*WIDTH-1:0] all_en,
    output logic [WIDTH-1:0]       wor_val,
    output logic [WIDTH-1:0]       any_en
);

    // Fold every driver into the running OR terms.
    always_comb begin
        wor_val = '0;
        any_en  = '0;
        for (int d = 0; d < N_TOT; d++) begin
            wor_val = wor_val | (all_val[d*WIDTH +: WIDTH] & all_en[d*WIDTH +: WIDTH]);
            any_en  = any_en  |  all_en[d*WIDTH +: WIDTH];
        end
    end

endmodule

// File: rtl/mdr_conflict_detect.sv
// Module: mdr_conflict_detect
// Flags each bit lane on which two or more drivers are enabled.
// Values are not compared, so agreeing drivers still count as a conflict.
// Assumes: drivers are packed driver-major, WIDTH bits each.
module mdr_conflict_detect #(
    parameter int WIDTH = 8,
    parameter int N_TOT = 4
) (
    input  logic [N_TOT*WIDTH-1:0] all_en,
    output logic [WIDTH-1:0]       multi_en
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_lane
        logic seen_one;
        logic seen_two;

        // Saturating two-level count of enables on this lane.
        always_comb begin
            seen_one = 1'b0;
            seen_two = 1'b0;
            for (int d = 0; d < N_TOT; d++) begin
                seen_two = seen_two | (seen_one & all_en[d*WIDTH + b]);
                seen_one = seen_one | all_en[d*WIDTH + b];
            end
        end

        assign multi_en[b] = seen_two;
    end

endmodule

// File: rtl/mdr_default_select.sv
// Module: mdr_default_select
// Applies the undriven default and the conflict policy to the merged lanes,
// and produces the driven and unknown flags.
// Assumes: wor_val, any_en and multi_en come from the same driver set.
module mdr_default_select
    import mdr_pkg::*;
#(
    parameter int               WIDTH          = 8,
    parameter undrv_mode_e      UNDRIVEN_MODE  = UNDRV_UNKNOWN,
    parameter bit               CONFLICT_POISON = 1'b1,
    parameter logic [WIDTH-1:0] UNKNOWN_VALUE  = '1
) (
    input  logic [WIDTH-1:0] wor_val,
    input  logic [WIDTH-1:0] any_en,
    input  logic [WIDTH-1:0] multi_en,
    output logic [WIDTH-1:0] res_val,
    output logic [WIDTH-1:0] res_driven,
    output logic [WIDTH-1:0] res_unknown
);

    localparam logic [WIDTH-1:0] FILL_VAL =
        (UNDRIVEN_MODE == UNDRV_UNKNOWN) ? UNKNOWN_VALUE :
        (UNDRIVEN_MODE == UNDRV_PULLUP)  ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
    localparam logic [WIDTH-1:0] FILL_IS_UNK =
        (UNDRIVEN_MODE == UNDRV_UNKNOWN) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
    localparam logic [WIDTH-1:0] PULL_MASK =
        mode_has_pull(UNDRIVEN_MODE) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

    logic [WIDTH-1:0] base_val;

    // Driven lanes keep the wired-OR, idle lanes take the fill constant.
    always_comb base_val = (any_en & wor_val) | (~any_en & FILL_VAL);

    // A pull makes the net look driven on every lane.
    always_comb res_driven = any_en | PULL_MASK;

    if (CONFLICT_POISON) begin : g_poison
        // Contested lanes are overwritten with the unknown marker.
        always_comb res_val     = (multi_en & UNKNOWN_VALUE) | (~multi_en & base_val);
        // Unknown flag covers idle lanes in unknown mode and contested lanes.
        always_comb res_unknown = (~any_en & FILL_IS_UNK) | multi_en;
    end else begin : g_accept
        // Contested lanes keep the wired-OR result.
        always_comb res_val     = base_val;
        // Only idle lanes in unknown mode are flagged.
        always_comb res_unknown = ~any_en & FILL_IS_UNK;
    end

endmodule

// File: rtl/multi_driver_resolver.sv
// Module: multi_driver_resolver (top)
// Resolves NUM_DRV internal drivers plus one external driver onto one net
// described by value/enable pairs. Purely combinational.
// Assumes: inputs are two-state; unknown is represented by UNKNOWN_VALUE.
module multi_driver_resolver
    import mdr_pkg::*;
#(
    parameter int               WIDTH           = 8,
    parameter int               NUM_DRV         = 3,
    parameter undrv_mode_e      UNDRIVEN_MODE   = UNDRV_UNKNOWN,
    parameter bit               CONFLICT_POISON = 1'b1,
    parameter logic [WIDTH-1:0] UNKNOWN_VALUE   = '1
) (
    input  logic [NUM_DRV*WIDTH-1:0] drv_val,
    input  logic [NUM_DRV*WIDTH-1:0] drv_en,
    input  logic [WIDTH-1:0]         ext_val,
    input  logic [WIDTH-1:0]         ext_en,
    output logic [WIDTH-1:0]         res_val,
    output logic [WIDTH-1:0]         res_driven,
    output logic [WIDTH-1:0]         res_conflict,
    output logic [WIDTH-1:0]         res_unknown
);

    localparam int N_TOT = NUM_DRV + 1;

    logic [N_TOT*WIDTH-1:0] all_val;
    logic [N_TOT*WIDTH-1:0] all_en;
    logic [WIDTH-1:0]       wor_val;
    logic [WIDTH-1:0]       any_en;
    logic [WIDTH-1:0]       multi_en;

    // The external source is appended as the highest-numbered driver.
    always_comb all_val = {ext_val, drv_val};
    always_comb all_en  = {ext_en,  drv_en};

    mdr_lane_merge #(
        .WIDTH (WIDTH),
        .N_TOT (N_TOT)
    ) u_merge (
        .all_val (all_val),
        .all_en  (all_en),
        .wor_val (wor_val),
        .any_en  (any_en)
    );

    mdr_conflict_detect #(
        .WIDTH (WIDTH),
        .N_TOT (N_TOT)
    ) u_conflict (
        .all_en   (all_en),
        .multi_en (multi_en)
    );

    mdr_default_select #(
        .WIDTH           (WIDTH),
        .UNDRIVEN_MODE   (UNDRIVEN_MODE),
        .CONFLICT_POISON (CONFLICT_POISON),
        .UNKNOWN_VALUE   (UNKNOWN_VALUE)
    ) u_select (
        .wor_val     (wor_val),
        .any_en      (any_en),
        .multi_en    (multi_en),
        .res_val     (res_val),
        .res_driven  (res_driven),
        .res_unknown (res_unknown)
    );

    // The conflict flag is reported under either policy.
    always_comb res_conflict = multi_en;

endmodule

// File: rtl/multi_driver_resolver_chk.sv
// Module: multi_driver_resolver_chk
// Port-level invariants of the resolver, attached with bind.
// Assumes: combinational design, so immediate assertions are used.
module multi_driver_resolver_chk
    import mdr_pkg::*;
#(
    parameter int               WIDTH           = 8,
    parameter int               NUM_DRV         = 3,
    parameter undrv_mode_e      UNDRIVEN_MODE   = UNDRV_UNKNOWN,
    parameter bit               CONFLICT_POISON = 1'b1,
    parameter logic [WIDTH-1:0] UNKNOWN_VALUE   = '1
) (
    input logic [NUM_DRV*WIDTH-1:0] drv_en,
    input logic [WIDTH-1:0]         ext_en,
    input logic [WIDTH-1:0]         res_val,
    input logic [WIDTH-1:0]         res_driven,
    input logic [WIDTH-1:0]         res_conflict,
    input logic [WIDTH-1:0]         res_unknown
);

    logic [WIDTH-1:0] chk_any;

    // Independent OR of all enables seen at the ports.
    always_comb begin
        chk_any = ext_en;
        for (int d = 0; d < NUM_DRV; d++) chk_any = chk_any | drv_en[d*WIDTH +: WIDTH];
    end

    // Port invariants evaluated whenever inputs or outputs move.
    always_comb begin
        assert_conflict_needs_drive_R7: assert ((res_conflict & ~chk_any) == '0)
            else $error("conflict flagged on a lane with no enable");
        if (!mode_has_pull(UNDRIVEN_MODE)) begin
            assert_driven_is_or_R2: assert (res_driven == chk_any)
                else $error("driven flag differs from OR of enables");
        end else begin
            assert_pull_forces_driven_R5: assert (res_driven == {WIDTH{1'b1}})
                else $error("driven flag not forced by pull");
        end
        if (UNDRIVEN_MODE == UNDRV_UNKNOWN) begin
            assert_idle_marks_unknown_R3: assert ((~chk_any & ~res_unknown) == '0)
                else $error("idle lane not flagged unknown");
        end
        if (CONFLICT_POISON) begin
            assert_poison_value_R8: assert (((res_val ^ UNKNOWN_VALUE) & res_conflict) == '0)
                else $error("contested lane not poisoned");
        end else begin
            assert_accept_no_unknown_R9: assert ((res_conflict & chk_any & res_unknown) == '0)
                else $error("contested lane flagged unknown in accept mode");
        end
    end

endmodule

bind multi_driver_resolver multi_driver_resolver_chk #(
    .WIDTH           (WIDTH),
    .NUM_DRV         (NUM_DRV),
    .UNDRIVEN_MODE   (UNDRIVEN_MODE),
    .CONFLICT_POISON (CONFLICT_POISON),
    .UNKNOWN_VALUE   (UNKNOWN_VALUE)
) u_chk (
    .drv_en       (drv_en),
    .ext_en       (ext_en),
    .res_val      (res_val),
    .res_driven   (res_driven),
    .res_conflict (res_conflict),
    .res_unknown  (res_unknown)
);

// File: tb/multi_driver_resolver_bench.sv
// Bench: directed scenarios applied to four parameter variants at once.
module multi_driver_resolver_bench;
    import mdr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int N  = 3;
    localparam int NI = 4;
    localparam logic [W-1:0] UNK_ALT = 8'h5A;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [N*W-1:0] drv_val;
    logic [N*W-1:0] drv_en;
    logic [W-1:0]   ext_val;
    logic [W-1:0]   ext_en;

    logic [W-1:0] o_val [NI];
    logic [W-1:0] o_drv [NI];
    logic [W-1:0] o_cf  [NI];
    logic [W-1:0] o_unk [NI];

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    multi_driver_resolver #(.WIDTH(W), .NUM_DRV(N)) u_multi_driver_resolver (
        .drv_val(drv_val), .drv_en(drv_en), .ext_val(ext_val), .ext_en(ext_en),
        .res_val(o_val[0]), .res_driven(o_drv[0]), .res_conflict(o_cf[0]), .res_unknown(o_unk[0]));
    multi_driver_resolver #(.WIDTH(W), .NUM_DRV(N), .UNDRIVEN_MODE(UNDRV_ZERO),
                            .CONFLICT_POISON(1'b0)) u_multi_driver_resolver_zero (
        .drv_val(drv_val), .drv_en(drv_en), .ext_val(ext_val), .ext_en(ext_en),
        .res_val(o_val[1]), .res_driven(o_drv[1]), .res_conflict(o_cf[1]), .res_unknown(o_unk[1]));
    multi_driver_resolver #(.WIDTH(W), .NUM_DRV(N), .UNDRIVEN_MODE(UNDRV_PULLUP),
                            .CONFLICT_POISON(1'b1), .UNKNOWN_VALUE(UNK_ALT)) u_multi_driver_resolver_pu (
        .drv_val(drv_val), .drv_en(drv_en), .ext_val(ext_val), .ext_en(ext_en),
        .res_val(o_val[2]), .res_driven(o_drv[2]), .res_conflict(o_cf[2]), .res_unknown(o_unk[2]));
    multi_driver_resolver #(.WIDTH(W), .NUM_DRV(N), .UNDRIVEN_MODE(UNDRV_PULLDOWN),
                            .CONFLICT_POISON(1'b0)) u_multi_driver_resolver_pd (
        .drv_val(drv_val), .drv_en(drv_en), .ext_val(ext_val), .ext_en(ext_en),
        .res_val(o_val[3]), .res_driven(o_drv[3]), .res_conflict(o_cf[3]), .res_unknown(o_unk[3]));

    // Configuration of instance k, for the bench's own reference model.
    function automatic int cfg_mode(int k);
        return k;
    endfunction
    function automatic bit cfg_poison(int k);
        return (k == 0) || (k == 2);
    endfunction
    function automatic logic [W-1:0] cfg_unk(int k);
        return (k == 2) ? UNK_ALT : {W{1'b1}};
    endfunction

    // Compare one output vector and report a mismatch.
    task automatic cmp(string tag, string what, int k, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s inst%0d %s: actual=%h expected=%h", tag, k, what, act, exp);
        end
    endtask

    // Apply stimulus, settle, and check every instance against the requirements.
    task automatic apply_check(string tag);
        @(negedge clk);
        #1;
        for (int k = 0; k < NI; k++) begin
            logic [W-1:0] ev, ed, ec, eu;
            for (int b = 0; b < W; b++) begin
                int cnt;
                logic orv;
                cnt = ext_en[b] ? 1 : 0;
                orv = ext_en[b] & ext_val[b];
                for (int d = 0; d < N; d++) begin
                    if (drv_en[d*W+b]) cnt++;
                    orv = orv | (drv_en[d*W+b] & drv_val[d*W+b]);
                end
                ec[b] = (cnt >= 2);
                ed[b] = (cnt > 0) || (cfg_mode(k) >= 2);
                eu[b] = 1'b0;
                if (cnt == 0) begin
                    case (cfg_mode(k))
                        0:       begin ev[b] = cfg_unk(k)[b]; eu[b] = 1'b1; end
                        2:       ev[b] = 1'b1;
                        default: ev[b] = 1'b0;
                    endcase
                end else if (cnt >= 2 && cfg_poison(k)) begin
                    ev[b] = cfg_unk(k)[b];
                    eu[b] = 1'b1;
                end else begin
                    ev[b] = orv;
                end
            end
            cmp(tag, "value",    k, o_val[k], ev);
            cmp(tag, "driven",   k, o_drv[k], ed);
            cmp(tag, "conflict", k, o_cf[k],  ec);
            cmp(tag, "unknown",  k, o_unk[k], eu);
        end
    endtask

    // Idle bus: undriven defaults (R3, R4, R5, R6).
    task automatic t_idle();
        drv_val = '1; drv_en = '0; ext_val = '1; ext_en = '0;
        apply_check("R3/R4/R5/R6 idle");
        drv_val = '0; ext_val = '0;
        apply_check("R3/R4/R5/R6 idle zero values");
    endtask

    // Each driver alone owns the bus, external included (R1, R2).
    task automatic t_single();
        for (int d = 0; d <= N; d++) begin
            drv_en = '0; ext_en = '0;
            drv_val = 24'hC3A55A; ext_val = 8'h96;
            if (d == N) ext_en = '1;
            else drv_en[d*W +: W] = '1;
            apply_check("R1/R2 single driver");
        end
    endtask

    // All enable/value combinations on every lane, lanes skewed (R1, R2, R7, R8, R9).
    task automatic t_exhaustive();
        for (int e = 0; e < 16; e++) begin
            for (int v = 0; v < 16; v++) begin
                for (int d = 0; d < N; d++) begin
                    drv_en[d*W +: W]  = {W{e[d]}};
                    drv_val[d*W +: W] = {W{v[d]}} ^ (8'h0F << d);
                end
                ext_en  = {W{e[N]}};
                ext_val = {W{v[N]}} ^ 8'h3C;
                apply_check("R1/R2/R7/R8/R9 exhaustive");
            end
        end
    endtask

    // Two drivers agreeing in value still conflict (R7, R8, R9).
    task automatic t_agree();
        drv_en = '0; ext_en = 8'hF0;
        drv_en[0 +: W] = 8'hFF;
        drv_val = '0; drv_val[0 +: W] = 8'hAA; ext_val = 8'hAA;
        apply_check("R7/R8/R9 agreeing drivers");
    endtask

    // Mixed per-bit patterns from a fixed seed (R1, R7).
    task automatic t_mixed();
        int unsigned seed = 32'h1234_5678;
        for (int i = 0; i < 200; i++) begin
            drv_val = $urandom(seed + i);
            drv_en  = $urandom(seed + 3*i + 7) & $urandom(seed + 5*i + 1);
            ext_val = 8'($urandom(seed + 11*i));
            ext_en  = 8'($urandom(seed + 13*i + 2));
            apply_check("R1/R7 mixed");
        end
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        #(CLK_PERIOD*100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Scenario sequence.
    initial begin
        drv_val = '0; drv_en = '0; ext_val = '0; ext_en = '0;
        repeat (2) @(posedge clk);
        t_idle();
        t_single();
        t_agree();
        t_exhaustive();
        t_mixed();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule